// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

This block holds the interrupt and mailbox state that one processor core uses to receive inter-processor interrupts. It keeps a 32-bit pending word and a 32-bit enable word. Two write-only ports set bits in the pending word and clear them. Eight 32-bit mailbox words carry message payloads. One registered interrupt line goes to the core.

Two parties write the bank. The core itself uses a request port that can read or write. A remote send engine has a write-only port. Only the low eight address bits take part in decoding. A read answers one cycle after its request.

The interrupt line is not a simple AND of pending and enable. Only a write to the set port can raise it. Only a write to the clear port can lower it. Between such writes the line keeps its value.

Top module: `ipi_regbank`

## Requirements
- R1: Register selection uses only address bits [7:0]; bits above 7 have no effect (an access at 0x1F24 reaches the same word as one at 0x24).
- R2: After reset the pending word, the enable word, every mailbox word, `irq`, `rd_valid`, `rd_bad` and `wr_err` are all zero.
- R3: A write to the enable word (offset 0x04) replaces all 32 bits, and a read of 0x04 returns it.
- R4: A write to the set port (offset 0x08) ORs the data into the pending word. If the updated pending word ANDed with enable is nonzero, `irq` is 1 from the next cycle. Otherwise `irq` keeps its value.
- R5: A write to the clear port (offset 0x0C) clears the pending bits that are 1 in the data. `irq` goes to 0 only when the resulting pending word is zero and enable is nonzero. Otherwise `irq` keeps its value.
- R6: `irq` changes only in the cycle after a set-port or clear-port write. A write to the enable word never changes `irq` on its own, even when it makes pending AND enable nonzero or zero.
- R7: The pending word (offset 0x00) is read-only. A write there leaves it unchanged and produces a one-cycle `wr_err` pulse in the following cycle.
- R8: Reads of the set port (0x08) and the clear port (0x0C) return zero.
- R9: Mailbox word k sits at offsets 0x20+4k through 0x23+4k (k = 0..7). Each word can be written and read back on its own, and does not affect the other words.
- R10: A core read (`cpu_req`=1, `cpu_we`=0) gives `rd_valid`=1 with `rd_data` in the next cycle. The data is the state before any write accepted in the same cycle.
- R11: A read of an unmapped offset (for example 0x10 or 0x40) returns zero with `rd_bad`=1 alongside `rd_valid`. A write to an unmapped offset changes no state.
- R12: The remote port (`rmt_we`) writes with the same effects as a core write. If both write in the same cycle, the remote write is applied and the core write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Core access request |
| cpu_we | input | 1 | Core access is a write (1) or a read (0) |
| cpu_addr | input | ADDR_W (16) | Core access address |
| cpu_wdata | input | DATA_W (32) | Core write data |
| rmt_we | input | 1 | Remote engine write strobe |
| rmt_addr | input | ADDR_W (16) | Remote write address |
| rmt_wdata | input | DATA_W (32) | Remote write data |
| rd_data | output | DATA_W (32) | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response pulse |
| rd_bad | output | 1 | Response is for an unmapped offset |
| wr_err | output | 1 | Pulse after a write to the read-only pending word |
| irq | output | 1 | Interrupt line to the core |

## Verification
The interrupt line is exercised with several sequences:
- A set while enable is zero, followed by an enable write. This separates the edge-driven line from a combinational AND.
- A partial clear, which must leave the line high.
- A full clear with enable zero, which must also leave the line high.
- A full clear with enable nonzero, which is the only case that lowers the line.

Mailbox accesses use an aliased high address and unaligned offsets to check the word indexing. A read taken in the same cycle as a remote write to the same word shows that read data comes from the state before the write. Same-cycle writes from both sources show which source wins.

// File: rtl/ipi_regbank_pkg.sv
package ipi_regbank_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_PEND,
    K_ENAB,
    K_SETP,
    K_CLRP,
    K_MBOX
  } reg_kind_e;

  localparam logic [7:0] OFS_PEND = 8'h00;
  localparam logic [7:0] OFS_ENAB = 8'h04;
  localparam logic [7:0] OFS_SETP = 8'h08;
  localparam logic [7:0] OFS_CLRP = 8'h0C;
  localparam logic [7:0] OFS_MBOX = 8'h20;

  // classify an 8-bit offset; mailbox window spans 4*n_mbox bytes
  function automatic reg_kind_e classify(input logic [7:0] ofs, input int unsigned n_mbox);
    reg_kind_e k;
    if (ofs == OFS_PEND)      k = K_PEND;
    else if (ofs == OFS_ENAB) k = K_ENAB;
    else if (ofs == OFS_SETP) k = K_SETP;
    else if (ofs == OFS_CLRP) k = K_CLRP;
    else if ((ofs >= OFS_MBOX) && (int'(ofs) < int'(OFS_MBOX) + 4 * int'(n_mbox)))
      k = K_MBOX;
    else
      k = K_NONE;
    return k;
  endfunction

  function automatic logic [7:0] mbox_word(input logic [7:0] ofs);
    logic [7:0] rel;
    rel = ofs - OFS_MBOX;
    return rel >> 2;
  endfunction

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_regbank_pkg::*;
#(
  parameter int MBOX_N = 8,
  parameter int IDX_W  = 3
) (
  input  logic [7:0]       ofs,
  output reg_kind_e        kind,
  output logic [IDX_W-1:0] idx
);
  logic [7:0] word_full;

  always_comb begin
    kind      = classify(ofs, MBOX_N);
    word_full = mbox_word(ofs);
    idx       = word_full[IDX_W-1:0];
  end
endmodule

// File: rtl/ipi_pend_ctrl.sv
module ipi_pend_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic              enab_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] pend_q,
  output logic [DATA_W-1:0] enab_q,
  output logic              irq_q
);
  function automatic logic [DATA_W-1:0] after_set(input logic [DATA_W-1:0] p, input logic [DATA_W-1:0] v);
    return p | v;
  endfunction

  function automatic logic [DATA_W-1:0] after_clr(input logic [DATA_W-1:0] p, input logic [DATA_W-1:0] v);
    return p & ~v;
  endfunction

  function automatic logic may_raise(input logic [DATA_W-1:0] p, input logic [DATA_W-1:0] e);
    return (p != '0) && ((p & e) != '0);
  endfunction

  function automatic logic may_lower(input logic [DATA_W-1:0] p, input logic [DATA_W-1:0] e);
    return (p == '0) && (e != '0);
  endfunction

  logic [DATA_W-1:0] pend_set_val;
  logic [DATA_W-1:0] pend_clr_val;
  logic              raise_ev;
  logic              lower_ev;

  always_comb begin
    pend_set_val = after_set(pend_q, wdata);
    pend_clr_val = after_clr(pend_q, wdata);
    raise_ev     = set_wr && may_raise(pend_set_val, enab_q);
    lower_ev     = clr_wr && may_lower(pend_clr_val, enab_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      enab_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (set_wr)       pend_q <= pend_set_val;
      else if (clr_wr)  pend_q <= pend_clr_val;
      if (enab_wr)      enab_q <= wdata;
      if (raise_ev)     irq_q  <= 1'b1;
      else if (lower_ev) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int MBOX_N = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rword
);
  logic [DATA_W-1:0] word_q [MBOX_N];

  for (genvar g = 0; g < MBOX_N; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q[g] <= '0;
      else if (wr && (int'(widx) == g))
        word_q[g] <= wdata;
    end
  end

  always_comb begin
    rword = '0;
    for (int i = 0; i < MBOX_N; i++)
      if (int'(ridx) == i) rword = word_q[i];
  end
endmodule

// File: rtl/ipi_regbank.sv
module ipi_regbank
  import ipi_regbank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int MBOX_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              rmt_we,
  input  logic [ADDR_W-1:0] rmt_addr,
  input  logic [DATA_W-1:0] rmt_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_bad,
  output logic              wr_err,
  output logic              irq
);
  localparam int IDX_W = (MBOX_N > 1) ? $clog2(MBOX_N) : 1;

  reg_kind_e         cpu_kind, rmt_kind, wr_kind;
  logic [IDX_W-1:0]  cpu_idx, rmt_idx, wr_idx;
  logic              cpu_wr, cpu_rd, wr_act;
  logic [DATA_W-1:0] wr_data;
  logic              set_wr, clr_wr, enab_wr, pend_wr, mbox_wr;
  logic [DATA_W-1:0] pend_q, enab_q, mbox_rword, rd_next;
  logic              irq_q;

  ipi_addr_decode #(.MBOX_N(MBOX_N), .IDX_W(IDX_W)) u_dec_cpu (
    .ofs(cpu_addr[7:0]), .kind(cpu_kind), .idx(cpu_idx)
  );

  ipi_addr_decode #(.MBOX_N(MBOX_N), .IDX_W(IDX_W)) u_dec_rmt (
    .ofs(rmt_addr[7:0]), .kind(rmt_kind), .idx(rmt_idx)
  );

  // remote source wins a same-cycle collision
  always_comb begin
    cpu_wr  = cpu_req && cpu_we;
    cpu_rd  = cpu_req && !cpu_we;
    wr_act  = rmt_we || cpu_wr;
    wr_kind = rmt_we ? rmt_kind  : cpu_kind;
    wr_idx  = rmt_we ? rmt_idx   : cpu_idx;
    wr_data = rmt_we ? rmt_wdata : cpu_wdata;
    set_wr  = wr_act && (wr_kind == K_SETP);
    clr_wr  = wr_act && (wr_kind == K_CLRP);
    enab_wr = wr_act && (wr_kind == K_ENAB);
    pend_wr = wr_act && (wr_kind == K_PEND);
    mbox_wr = wr_act && (wr_kind == K_MBOX);
  end

  ipi_pend_ctrl #(.DATA_W(DATA_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_wr(set_wr), .clr_wr(clr_wr), .enab_wr(enab_wr), .wdata(wr_data),
    .pend_q(pend_q), .enab_q(enab_q), .irq_q(irq_q)
  );

  ipi_mailbox #(.MBOX_N(MBOX_N), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mbox (
    .clk(clk), .rst_n(rst_n),
    .wr(mbox_wr), .widx(wr_idx), .wdata(wr_data),
    .ridx(cpu_idx), .rword(mbox_rword)
  );

  always_comb begin
    case (cpu_kind)
      K_PEND:  rd_next = pend_q;
      K_ENAB:  rd_next = enab_q;
      K_MBOX:  rd_next = mbox_rword;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_bad   <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      rd_valid <= cpu_rd;
      rd_bad   <= cpu_rd && (cpu_kind == K_NONE);
      rd_data  <= cpu_rd ? rd_next : '0;
      wr_err   <= pend_wr;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/ipi_regbank_chk.sv
module ipi_regbank_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_rd,
  input logic              set_wr,
  input logic              clr_wr,
  input logic              pend_wr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] pend_q,
  input logic [DATA_W-1:0] enab_q,
  input logic              irq,
  input logic              rd_valid,
  input logic              rd_bad,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_err
);
  // R6
  irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_wr));
  // R6
  irq_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_wr));
  // R4
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && (((pend_q | wr_data) & enab_q) != '0)) |=> irq);
  // R5
  irq_hold_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && irq && ((pend_q & ~wr_data) != '0)) |=> irq);
  // R7
  pend_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> (wr_err && $stable(pend_q)));
  // R10
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |=> rd_valid);
  // R10
  no_spur_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> !rd_valid);
  // R11
  bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |-> (rd_valid && rd_data == '0));
endmodule

bind ipi_regbank ipi_regbank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .set_wr(set_wr), .clr_wr(clr_wr),
  .pend_wr(pend_wr), .wr_data(wr_data), .pend_q(pend_q), .enab_q(enab_q),
  .irq(irq), .rd_valid(rd_valid), .rd_bad(rd_bad), .rd_data(rd_data), .wr_err(wr_err)
);

// File: tb/test_ipi_regbank.sv
module test_ipi_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, rmt_we = 1'b0;
  logic [15:0] cpu_addr = '0, rmt_addr = '0;
  logic [31:0] cpu_wdata = '0, rmt_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid, rd_bad, wr_err, irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] data;
    logic        bad;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // reference state, kept from the requirements
  logic [31:0] m_pend = '0, m_enab = '0;
  logic [31:0] m_mbox [8];
  logic        m_irq = 1'b0;
  logic        m_err = 1'b0;

  always #2.5 clk = ~clk;

  ipi_regbank i_ipi_regbank (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .rmt_we(rmt_we), .rmt_addr(rmt_addr), .rmt_wdata(rmt_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_bad(rd_bad), .wr_err(wr_err), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_wr(input logic [15:0] a, input logic [31:0] d);
    logic [7:0] o;
    o = a[7:0];
    m_err = 1'b0;
    if (o == 8'h00) m_err = 1'b1;
    else if (o == 8'h04) m_enab = d;
    else if (o == 8'h08) begin
      m_pend = m_pend | d;
      if (m_pend != 0 && (m_pend & m_enab) != 0) m_irq = 1'b1;
    end else if (o == 8'h0C) begin
      m_pend = m_pend & ~d;
      if (m_pend == 0 && m_enab != 0) m_irq = 1'b0;
    end else if (o >= 8'h20 && o <= 8'h3F) m_mbox[(o - 8'h20) / 4] = d;
  endfunction

  function automatic exp_t model_rd(input logic [15:0] a, input string tag);
    exp_t e;
    logic [7:0] o;
    o = a[7:0];
    e.tag = tag; e.bad = 1'b0; e.data = '0;
    if (o == 8'h00) e.data = m_pend;
    else if (o == 8'h04) e.data = m_enab;
    else if (o == 8'h08 || o == 8'h0C) e.data = '0;
    else if (o >= 8'h20 && o <= 8'h3F) e.data = m_mbox[(o - 8'h20) / 4];
    else e.bad = 1'b1;
    return e;
  endfunction

  task automatic cpu_write(input logic [15:0] a, input logic [31:0] d);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic rmt_write(input logic [15:0] a, input logic [31:0] d);
    rmt_we = 1'b1; rmt_addr = a; rmt_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    rmt_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [15:0] a, input string tag);
    sb_q.push_back(model_rd(a, tag));
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  // core and remote write in one cycle: remote applies, core dropped
  task automatic both_write(input logic [15:0] ca, input logic [31:0] cd,
                            input logic [15:0] ra, input logic [31:0] rd);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = ca; cpu_wdata = cd;
    rmt_we = 1'b1; rmt_addr = ra; rmt_wdata = rd;
    model_wr(ra, rd);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0; rmt_we = 1'b0;
  endtask

  // read with a same-cycle remote write: old value expected
  task automatic read_during_rmt(input logic [15:0] a, input logic [31:0] d, input string tag);
    sb_q.push_back(model_rd(a, tag));
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    rmt_we = 1'b1; rmt_addr = a; rmt_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    cpu_req = 1'b0; rmt_we = 1'b0;
  endtask

  // monitor: pops expected responses as they appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (sb_q.size() == 0) begin
          check("R10 unexpected response", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check({e.tag, " data"}, rd_data, e.data);
          check({e.tag, " bad flag (R11)"}, {31'd0, rd_bad}, {31'd0, e.bad});
        end
      end else if (rd_bad) begin
        check("R11 bad without valid", 32'd1, 32'd0);
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_mbox[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2 irq", {31'd0, irq}, 32'd0);
    check("R2 wr_err", {31'd0, wr_err}, 32'd0);
    check("R2 rd_valid", {31'd0, rd_valid}, 32'd0);
    cpu_read(16'h0000, "R2 pending");
    cpu_read(16'h0004, "R2 enable");
    for (int k = 0; k < 8; k++) cpu_read(16'h0020 + 16'(4 * k), "R2 mailbox");

    // R4 set with enable zero: no raise
    cpu_write(16'h0008, 32'h0000_0011);
    check("R4 no raise en=0", {31'd0, irq}, {31'd0, m_irq});
    cpu_read(16'h0000, "R4 pending after set");
    // R6 and R3 enable write alone never raises
    cpu_write(16'h0004, 32'hF0F0_0001);
    check("R6 enable write keeps irq", {31'd0, irq}, 32'd0);
    cpu_read(16'h0004, "R3 enable readback");
    cpu_write(16'h0004, 32'h0000_0010);
    cpu_read(16'h0004, "R3 enable replaced");
    // R4 raise
    cpu_write(16'h0008, 32'h0000_0100);
    check("R4 raise", {31'd0, irq}, 32'd1);
    cpu_read(16'h0000, "R4 pending or");
    // R5 partial clear keeps irq
    cpu_write(16'h000C, 32'h0000_0010);
    check("R5 partial clear holds", {31'd0, irq}, 32'd1);
    // R6 enable to zero does not lower
    cpu_write(16'h0004, 32'h0);
    check("R6 enable zero holds", {31'd0, irq}, 32'd1);
    // R5 full clear with enable zero: holds
    cpu_write(16'h000C, 32'hFFFF_FFFF);
    check("R5 clear en=0 holds", {31'd0, irq}, 32'd1);
    cpu_read(16'h0000, "R5 pending cleared");
    // R5 clear to zero with enable nonzero: lowers
    cpu_write(16'h0004, 32'h0000_0002);
    cpu_write(16'h000C, 32'h0000_0000);
    check("R5 lower", {31'd0, irq}, 32'd0);

    // R7 pending read-only
    cpu_write(16'h0008, 32'h0000_0004);
    cpu_write(16'h0000, 32'hDEAD_BEEF);
    check("R7 wr_err pulse", {31'd0, wr_err}, 32'd1);
    @(negedge clk);
    check("R7 wr_err one cycle", {31'd0, wr_err}, 32'd0);
    cpu_read(16'h0000, "R7 pending unchanged");
    // R8
    cpu_read(16'h0008, "R8 set port reads zero");
    cpu_read(16'h000C, "R8 clear port reads zero");

    // R9 mailboxes
    for (int k = 0; k < 8; k++) cpu_write(16'h0020 + 16'(4 * k), 32'hA500_0000 + 32'(k));
    for (int k = 0; k < 8; k++) cpu_read(16'h0020 + 16'(4 * k), "R9 mailbox word");
    cpu_write(16'h0027, 32'h1234_5678);
    cpu_read(16'h0024, "R9 unaligned offset word1");
    // R1 high address bits ignored
    cpu_write(16'h1F2C, 32'hCAFE_0003);
    cpu_read(16'h002C, "R1 alias write");
    cpu_read(16'hFF04, "R1 alias read enable");

    // R11 unmapped
    cpu_read(16'h0010, "R11 unmapped 0x10");
    cpu_read(16'h0040, "R11 unmapped 0x40");
    cpu_write(16'h0014, 32'hFFFF_FFFF);
    cpu_read(16'h0000, "R11 pending after unmapped write");
    cpu_read(16'h0004, "R11 enable after unmapped write");
    for (int k = 0; k < 8; k++) cpu_read(16'h0020 + 16'(4 * k), "R11 mailbox after unmapped write");

    // R12 remote writes
    rmt_write(16'h0030, 32'h0BAD_F00D);
    cpu_read(16'h0030, "R12 remote mailbox");
    rmt_write(16'h0008, 32'h0000_0002);
    check("R12 remote set raises", {31'd0, irq}, 32'd1);
    both_write(16'h0004, 32'h0000_00AA, 16'h0004, 32'h0000_0055);
    cpu_read(16'h0004, "R12 collision remote wins");
    both_write(16'h0034, 32'h7777_7777, 16'h000C, 32'hFFFF_FFFF);
    check("R12 remote clear lowers", {31'd0, irq}, 32'd0);
    cpu_read(16'h0034, "R12 core write dropped");

    // R10 read sees pre-write state
    read_during_rmt(16'h0028, 32'h5555_AAAA, "R10 read before same-cycle write");
    cpu_read(16'h0028, "R10 write then visible");

    repeat (3) @(negedge clk);
    check("R10 all responses seen", 32'(sb_q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule